// File: doc/BRIEF.md
# Nonvolatile memory write/erase controller

This block is the firmware-facing front end for programming on-chip nonvolatile memory. Firmware selects a memory region and an operation through a small register file, proves intent by writing a two-byte key to a storage-less key register, and then sets a start bit. The controller hands a command (region, operation code, one-cycle go pulse) to the memory side. It holds the start bit high while an internal programming timer runs, and it raises a sticky completion flag when the timer expires.

The start bit is set-only from software and clear-only from hardware. Region and erase selection are frozen while an operation is in flight. An abort input or a system reset during an operation leaves a sticky error flag for firmware to inspect. A separate power-on clear wipes every bit, including the error flag and the write-enable bit.

Register map: address 0 is the control register, address 1 is the key register, address 2 is the flag register, and address 3 reads as zero. Control register bits are: region [1:0], erase enable [2], write enable [3], start [4], error [5]. Bits [7:6] read as zero. The flag register holds the completion flag at bit 0.

Top module: `nvm_wrctl`

## Requirements
- R1: After power-on clear (por_n low), the control and flag registers read 0, mem_busy, mem_go and nvm_irq are 0.
- R2: The key register (address 1) and address 3 always read 8'h00, whatever was written to them.
- R3: A write of 1 to start (bit 4) is accepted only if the two register writes immediately before it were 8'h55 then 8'hAA to address 1. Idle cycles between writes do not break the sequence. Any other order, or any other register write in between, leaves start at 0.
- R4: A start is accepted only when the stored write-enable bit (bit 3) is already 1.
- R5: Writing 0 to start has no effect. Once accepted, start (and mem_busy) stays 1 for exactly PROG_CYCLES cycles, and then hardware clears it.
- R6: mem_op encodes the operation as 2'b11 erase+write, 2'b10 erase, 2'b01 write. Region 2'b00 (data EEPROM) always gives 2'b11. Region 2'b10 (program flash) gives 2'b10 if erase enable is set, otherwise 2'b01. Any region with bit 0 set (ID/configuration space) gives 2'b01.
- R7: nvm_irq (flag bit 0) is set when an operation completes. It stays set until firmware writes 0 to bit 0 of address 2; writing 1 there has no effect.
- R8: While start is 1, writes to region and erase enable are ignored. mem_region and mem_op stay stable.
- R9: abort while start is 1 clears start at the next edge, sets the error flag (bit 5), and does not set nvm_irq.
- R10: A system reset (rst_n low) while start is 1 sets the error flag; otherwise the error flag keeps its value through a system reset. Every other bit is cleared by the system reset.
- R11: The error flag is cleared only by writing 0 to bit 5 of the control register. Writing 1 there has no effect, and a successful completion leaves it unchanged.
- R12: mem_go is a one-cycle pulse in the first cycle mem_busy is high, and it never occurs while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on clear, active low, synchronous; clears all state |
| rst_n | input | 1 | System reset, active low, synchronous; error flag captured |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr (combinational) |
| abort | input | 1 | Cancels an operation in flight |
| mem_go | output | 1 | One-cycle command pulse to the memory |
| mem_busy | output | 1 | Operation in flight (mirror of start) |
| mem_region | output | 2 | Region of the current command |
| mem_op | output | 2 | Operation code of the current command |
| nvm_irq | output | 1 | Sticky completion flag |

## Verification
The bench builds the block with PROG_CYCLES at its floor of 16 and the default key bytes 8'h55/8'hAA. The short timer lets the bench run many complete operations: every region/erase combination, an abort mid-flight, and system resets both during and outside an operation. Each cycle is compared against a behavioural model of the register file and timer. Targeted checks cover the exact busy length, the broken-key orderings and the writes that must be ignored while busy.

// File: rtl/nvm_wrctl_pkg.sv
package nvm_wrctl_pkg;

    // register addresses
    localparam int ADR_CTRL = 0;
    localparam int ADR_KEY  = 1;
    localparam int ADR_FLAG = 2;

    // control register bit positions
    localparam int B_ERASE = 2;
    localparam int B_WREN  = 3;
    localparam int B_START = 4;
    localparam int B_ERR   = 5;
    localparam int B_IRQ   = 0;

    typedef enum logic [1:0] {
        OP_NONE        = 2'b00,
        OP_WRITE       = 2'b01,
        OP_ERASE       = 2'b10,
        OP_ERASE_WRITE = 2'b11
    } nvm_op_e;

    typedef enum logic [1:0] {
        KS_IDLE  = 2'b00,
        KS_HALF  = 2'b01,
        KS_ARMED = 2'b10
    } key_st_e;

    typedef struct packed {
        logic [1:0] region;
        logic       erase;
        logic       wren;
        logic       start;
        logic       err;
        logic       irq;
        logic       go;
    } ctl_t;

endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
    import nvm_wrctl_pkg::*;
#(
    parameter int            DW      = 8,
    parameter logic [DW-1:0] KEY_A   = 8'h55,
    parameter logic [DW-1:0] KEY_B   = 8'hAA
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          key_sel,
    input  logic [DW-1:0] wdata,
    output logic          armed
);

    key_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (!key_sel) begin
                st_d = KS_IDLE;
            end else if (wdata == KEY_A) begin
                st_d = KS_HALF;
            end else if (wdata == KEY_B && st_q == KS_HALF) begin
                st_d = KS_ARMED;
            end else begin
                st_d = KS_IDLE;
            end
        end
        if (!rst_n || !por_n) begin
            st_d = KS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign armed = (st_q == KS_ARMED);

endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic load,
    input  logic cancel,
    output logic done
);

    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (load) begin
            tm_d.run = 1'b1;
            tm_d.cnt = CW'(CYCLES - 1);
        end else if (tm_q.run) begin
            if (cancel || tm_q.cnt == '0) begin
                tm_d.run = 1'b0;
            end else begin
                tm_d.cnt = tm_q.cnt - 1'b1;
            end
        end
        if (!rst_n || !por_n) begin
            tm_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        tm_q <= tm_d;
    end

    assign done = tm_q.run && (tm_q.cnt == '0);

endmodule

// File: rtl/nvm_op_decode.sv
module nvm_op_decode
    import nvm_wrctl_pkg::*;
(
    input  logic [1:0] region,
    input  logic       erase,
    output nvm_op_e    op
);

    always_comb begin
        if (region[0]) begin
            op = OP_WRITE;
        end else if (region[1]) begin
            op = erase ? OP_ERASE : OP_WRITE;
        end else begin
            op = OP_ERASE_WRITE;
        end
    end

endmodule

// File: rtl/nvm_wrctl.sv
module nvm_wrctl
    import nvm_wrctl_pkg::*;
#(
    parameter int            PROG_CYCLES = 16,
    parameter int            DW          = 8,
    parameter int            ADDR_W      = 2,
    parameter logic [DW-1:0] KEY_FIRST   = 8'h55,
    parameter logic [DW-1:0] KEY_SECOND  = 8'hAA
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              abort,
    output logic              mem_go,
    output logic              mem_busy,
    output logic [1:0]        mem_region,
    output logic [1:0]        mem_op,
    output logic              nvm_irq
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(ADR_KEY);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ADR_FLAG);

    ctl_t    st_d, st_q;
    logic    armed;
    logic    tm_done;
    logic    accept;
    logic    wr_ctrl;
    logic    wr_flag;
    nvm_op_e op;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_flag = reg_wr && (reg_addr == A_FLAG);

    nvm_key_seq #(
        .DW    (DW),
        .KEY_A (KEY_FIRST),
        .KEY_B (KEY_SECOND)
    ) u_key (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .key_sel (reg_addr == A_KEY),
        .wdata   (reg_wdata),
        .armed   (armed)
    );

    assign accept = wr_ctrl && reg_wdata[B_START] && armed
                    && st_q.wren && !st_q.start && rst_n && por_n;

    nvm_prog_timer #(
        .CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk    (clk),
        .por_n  (por_n),
        .rst_n  (rst_n),
        .load   (accept),
        .cancel (abort && st_q.start),
        .done   (tm_done)
    );

    nvm_op_decode u_dec (
        .region (st_q.region),
        .erase  (st_q.erase),
        .op     (op)
    );

    always_comb begin
        st_d    = st_q;
        st_d.go = 1'b0;

        if (wr_ctrl) begin
            if (!st_q.start) begin
                st_d.region = reg_wdata[1:0];
                st_d.erase  = reg_wdata[B_ERASE];
            end
            st_d.wren = reg_wdata[B_WREN];
            if (!reg_wdata[B_ERR]) begin
                st_d.err = 1'b0;
            end
            if (accept) begin
                st_d.start = 1'b1;
                st_d.go    = 1'b1;
            end
        end

        if (wr_flag && !reg_wdata[B_IRQ]) begin
            st_d.irq = 1'b0;
        end

        if (st_q.start && abort) begin
            st_d.start = 1'b0;
            st_d.err   = 1'b1;
        end else if (st_q.start && tm_done) begin
            st_d.start = 1'b0;
            st_d.irq   = 1'b1;
        end

        if (!rst_n) begin
            st_d     = '0;
            st_d.err = st_q.err | st_q.start;
        end
        if (!por_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata[1:0]     = st_q.region;
            reg_rdata[B_ERASE] = st_q.erase;
            reg_rdata[B_WREN]  = st_q.wren;
            reg_rdata[B_START] = st_q.start;
            reg_rdata[B_ERR]   = st_q.err;
        end else if (reg_addr == A_FLAG) begin
            reg_rdata[B_IRQ] = st_q.irq;
        end
    end

    assign mem_go     = st_q.go;
    assign mem_busy   = st_q.start;
    assign mem_region = st_q.region;
    assign mem_op     = op;
    assign nvm_irq    = st_q.irq;

endmodule

// File: rtl/nvm_wrctl_chk.sv
module nvm_wrctl_chk #(
    parameter int DW     = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic [DW-1:0]     reg_rdata,
    input logic              abort,
    input logic              mem_go,
    input logic              mem_busy,
    input logic [1:0]        mem_region,
    input logic [1:0]        mem_op,
    input logic              nvm_irq,
    input logic              err_q,
    input logic              wr_en_q
);

    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (reg_addr == ADDR_W'(1)) |-> (reg_rdata == '0)); // R2

    AST_START_FROM_CTRL_WRITE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(mem_busy) |-> ($past(reg_wr) && $past(reg_addr) == ADDR_W'(0) && $past(reg_wdata[4]))); // R3

    AST_START_NEEDS_WREN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(mem_busy) |-> $past(wr_en_q)); // R4

    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ($fell(mem_busy) && !$past(abort)) |-> nvm_irq); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (nvm_irq && !(reg_wr && reg_addr == ADDR_W'(2) && !reg_wdata[0])) |=> nvm_irq); // R7

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (mem_busy && $past(mem_busy)) |-> ($stable(mem_region) && $stable(mem_op))); // R8

    AST_ABORT_ERR: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (abort && mem_busy) |=> (!mem_busy && err_q)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (err_q && !(reg_wr && reg_addr == ADDR_W'(0) && !reg_wdata[5])) |=> err_q); // R11

    AST_GO_IN_BUSY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        mem_go |-> mem_busy); // R12

    AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        mem_go |=> !mem_go); // R12

    AST_GO_ON_ROSE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(mem_busy) |-> mem_go); // R12

endmodule

bind nvm_wrctl nvm_wrctl_chk #(
    .DW     (DW),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .abort      (abort),
    .mem_go     (mem_go),
    .mem_busy   (mem_busy),
    .mem_region (mem_region),
    .mem_op     (mem_op),
    .nvm_irq    (nvm_irq),
    .err_q      (st_q.err),
    .wr_en_q    (st_q.wren)
);

// File: tb/sim_nvm_wrctl.sv
`timescale 1ns/1ps
module sim_nvm_wrctl;

    localparam int N = 16;

    logic       clk = 1'b0;
    logic       por_n, rst_n, reg_wr, abort;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       mem_go, mem_busy, nvm_irq;
    logic [1:0] mem_region, mem_op;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    nvm_wrctl #(.PROG_CYCLES(N)) u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .abort(abort), .mem_go(mem_go), .mem_busy(mem_busy),
        .mem_region(mem_region), .mem_op(mem_op), .nvm_irq(nvm_irq)
    );

    // behavioural reference model
    logic [1:0] m_region = 0;
    bit m_erase = 0, m_wren = 0, m_start = 0, m_err = 0, m_irq = 0, m_go = 0;
    int m_seq = 0, m_rem = 0;
    bit cmp_en = 0;

    function automatic logic [7:0] m_read(input logic [1:0] a);
        if (a == 2'd0) return {2'b00, m_err, m_start, m_wren, m_erase, m_region};
        if (a == 2'd2) return {7'd0, m_irq};
        return 8'h00;
    endfunction

    function automatic logic [1:0] m_op();
        if (m_region[0]) return 2'b01;
        if (m_region[1]) return m_erase ? 2'b10 : 2'b01;
        return 2'b11;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit ostart, owren, acc;
        int oseq;
        ostart = m_start; owren = m_wren; oseq = m_seq;
        if (!por_n) begin
            m_region = 0; m_erase = 0; m_wren = 0; m_start = 0; m_err = 0;
            m_irq = 0; m_go = 0; m_seq = 0; m_rem = 0; cmp_en = 1;
        end else if (!rst_n) begin
            m_err = m_err | m_start;
            m_region = 0; m_erase = 0; m_wren = 0; m_start = 0;
            m_irq = 0; m_go = 0; m_seq = 0; m_rem = 0;
        end else begin
            m_go = 0;
            acc = reg_wr && reg_addr == 2'd0 && reg_wdata[4] && oseq == 2 && owren && !ostart;
            if (reg_wr) begin
                if (reg_addr == 2'd0) begin
                    if (!ostart) begin
                        m_region = reg_wdata[1:0];
                        m_erase  = reg_wdata[2];
                    end
                    m_wren = reg_wdata[3];
                    if (!reg_wdata[5]) m_err = 0;
                    if (acc) begin m_start = 1; m_rem = N; m_go = 1; end
                end
                if (reg_addr == 2'd2 && !reg_wdata[0]) m_irq = 0;
                if (reg_addr == 2'd1) begin
                    if (reg_wdata == 8'h55) m_seq = 1;
                    else if (reg_wdata == 8'hAA && oseq == 1) m_seq = 2;
                    else m_seq = 0;
                end else m_seq = 0;
            end
            if (ostart) begin
                if (abort) begin m_start = 0; m_err = 1; m_rem = 0; end
                else if (m_rem == 1) begin m_start = 0; m_irq = 1; m_rem = 0; end
                else m_rem = m_rem - 1;
            end
        end
        #1;
        if (cmp_en) begin
            chk("R5 busy", {7'd0, mem_busy}, {7'd0, m_start});
            chk("R7 irq", {7'd0, nvm_irq}, {7'd0, m_irq});
            chk("R12 go", {7'd0, mem_go}, {7'd0, m_go});
            chk("R6 op", {6'd0, mem_op}, {6'd0, m_op()});
            chk("R8 region", {6'd0, mem_region}, {6'd0, m_region});
            chk("R11 rdata", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic unlock();
        wr(2'd1, 8'h55);
        wr(2'd1, 8'hAA);
    endtask

    task automatic launch(input logic [7:0] c);
        wr(2'd0, c);
        unlock();
        wr(2'd0, c | 8'h10);
    endtask

    task automatic wait_idle();
        while (mem_busy) @(negedge clk);
    endtask

    task automatic sysrst();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        int cnt;
        por_n = 0; rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; abort = 0;
        repeat (3) @(negedge clk);
        por_n = 1; rst_n = 1;

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl after por", v, 8'h00);
        rd(2'd2, v); chk("R1 flag after por", v, 8'h00);
        chk("R1 busy after por", {7'd0, mem_busy}, 8'h00);

        // R5/R6/R12 data EEPROM operation, exact busy length
        launch(8'h08);
        chk("R12 go pulse", {7'd0, mem_go}, 8'h01);
        chk("R6 op region00", {6'd0, mem_op}, 8'h03);
        cnt = 1;
        forever begin
            @(negedge clk);
            if (mem_busy) cnt++; else break;
        end
        chk("R5 busy length", 8'(cnt), 8'(N));
        rd(2'd2, v); chk("R7 irq after done", v, 8'h01);
        rd(2'd0, v); chk("R11 err untouched by done", v, 8'h08);

        // R7 flag clear semantics
        wr(2'd2, 8'h01); rd(2'd2, v); chk("R7 write 1 no effect", v, 8'h01);
        wr(2'd2, 8'h00); rd(2'd2, v); chk("R7 write 0 clears", v, 8'h00);

        // R6 flash write, R8/R5 ignored writes while busy
        launch(8'h0A);
        chk("R6 op flash write", {6'd0, mem_op}, 8'h01);
        wr(2'd0, 8'h0D);
        rd(2'd0, v); chk("R8 region frozen, R5 start kept", v, 8'h1A);
        wait_idle();
        rd(2'd0, v); chk("R5 hw cleared start", v, 8'h0A);

        launch(8'h0E);
        chk("R6 op flash erase", {6'd0, mem_op}, 8'h02);
        wait_idle();
        launch(8'h0D);
        chk("R6 op id space", {6'd0, mem_op}, 8'h01);
        wait_idle();
        wr(2'd2, 8'h00);

        // R9 abort
        launch(8'h0C);
        chk("R6 op eeprom erase bit", {6'd0, mem_op}, 8'h03);
        repeat (3) @(negedge clk);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        rd(2'd0, v); chk("R9 abort sets err", v, 8'h2C);
        repeat (N + 2) @(negedge clk);
        rd(2'd2, v); chk("R9 no irq on abort", v, 8'h00);

        // R11 error clear
        wr(2'd0, 8'h2C); rd(2'd0, v); chk("R11 write 1 keeps err", v, 8'h2C);
        wr(2'd0, 8'h0C); rd(2'd0, v); chk("R11 write 0 clears err", v, 8'h0C);

        // R3 key sequence
        wr(2'd0, 8'h08); wr(2'd0, 8'h18);
        chk("R3 no key", {7'd0, mem_busy}, 8'h00);
        wr(2'd1, 8'hAA); wr(2'd1, 8'h55); wr(2'd0, 8'h18);
        chk("R3 reversed key", {7'd0, mem_busy}, 8'h00);
        wr(2'd1, 8'h55); wr(2'd2, 8'h01); wr(2'd1, 8'hAA); wr(2'd0, 8'h18);
        chk("R3 interrupted key", {7'd0, mem_busy}, 8'h00);
        wr(2'd1, 8'h55); repeat (3) @(negedge clk); wr(2'd1, 8'hAA); wr(2'd0, 8'h18);
        chk("R3 key with idle gaps", {7'd0, mem_busy}, 8'h01);
        wait_idle();

        // R4 write enable
        launch(8'h00);
        chk("R4 no wren", {7'd0, mem_busy}, 8'h00);
        rd(2'd0, v); chk("R4 start stays 0", v, 8'h00);

        // R10 system reset
        launch(8'h08);
        repeat (2) @(negedge clk);
        sysrst();
        rd(2'd0, v); chk("R10 reset mid-op sets err", v, 8'h20);
        chk("R10 busy cleared", {7'd0, mem_busy}, 8'h00);
        sysrst();
        rd(2'd0, v); chk("R10 err kept over reset", v, 8'h20);
        @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
        rd(2'd0, v); chk("R1 por clears err", v, 8'h00);

        // R2 key register and spare address
        wr(2'd1, 8'h55); rd(2'd1, v); chk("R2 key reads zero", v, 8'h00);
        wr(2'd3, 8'hFF); rd(2'd3, v); chk("R2 spare reads zero", v, 8'h00);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule